// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the start-up and refresh duties for an asynchronous DRAM. After reset it counts out the power-up pause. It then runs a fixed number of CAS-before-RAS refresh cycles as the initialisation cycles. After that it declares the memory ready for normal traffic. From then on a pacing timer produces one refresh demand per row slot, so that every row is refreshed once per retention period. The period can be doubled for long-retention parts. An input selects a slower pace for battery-backup operation.

The sequencer shares the strobe pins with the access controller. It raises a request whenever it needs the pins. Once the controller has closed its row and returns the grant, the sequencer drives RAS, all CAS lines and write-enable itself. Refresh demands that arrive while the grant is withheld are counted, up to a limit, and issued back to back once the pins are granted.

A low-power request puts the memory into self-refresh. The block performs a CBR entry and holds RAS and CAS low for a minimum time, and for as long as the request stays asserted. On exit it observes the longer self-refresh precharge. It then refreshes every row in a burst before normal access is allowed again. All timing values are parameters in clock cycles; the defaults assume a 100 MHz clock.

Top module: `drfs_seq`

## Requirements
- R1: While reset is held, and for PAUSE_CYC cycles after it is released, ref_req, ready and strobe_en are low, RAS is high and every CAS line is high. ref_req first reads high PAUSE_CYC cycles after reset is released.
- R2: Exactly INIT_CYCLES refresh cycles are issued after the pause, and ready first goes high only after the last of them has finished.
- R3: In every refresh, all CAS lines go low at least CSR_CYC cycles before RAS falls and stay low for as long as RAS is low. write-enable stays high throughout. RAS stays low for exactly RAS_LOW_CYC cycles in an ordinary refresh.
- R4: While ready is high and slow_pace is low, one refresh is issued per interval of RETENTION_CYC/ROWS cycles. When LONG_RET is 1 the interval is twice as long.
- R5: Refresh demands that arrive while the grant is withheld are kept, up to MAX_PEND of them, and are issued back to back once the grant returns. Demands beyond MAX_PEND are dropped.
- R6: RAS and CAS do not move while ref_gnt is low. ref_req is high whenever a refresh is waiting.
- R7: A high lp_req while ready starts a CBR entry into self-refresh. RAS then stays low for at least SELF_MIN cycles, and for as long as lp_req stays high.
- R8: After self-refresh ends, RAS stays high for at least RPS_CYC cycles before it falls again.
- R9: After self-refresh, exactly ROWS refresh cycles are issued before ready returns high.
- R10: While slow_pace is high, refreshes in the ready state are issued once every BATT_INTERVAL cycles.
- R11: ready is low during the pause, the initialisation cycles, self-refresh and the post-exit burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Access controller has closed its row and hands over the strobes |
| lp_req | input | 1 | Request to enter, and while high to stay in, self-refresh |
| slow_pace | input | 1 | Selects the battery-backup refresh pace |
| ref_req | output | 1 | Sequencer needs the strobe pins |
| ready | output | 1 | Normal access permitted |
| strobe_en | output | 1 | Sequencer is driving the strobe pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NCAS | Column strobes, active low, moved together |
| we_n | output | 1 | Write enable, held high |

## Verification
The assertions assume that the access controller behaves in one way. Once it grants the pins it keeps ref_gnt high for as long as ref_req stays high, and it withdraws the grant only while no refresh cycle is in flight. The stimulus follows this rule. It removes the grant only at moments when the strobes are idle, and it restores the grant at times placed well clear of the pacing ticks. This lets the count of back-to-back refreshes be known exactly. lp_req is raised only in the ready state between refreshes, so a self-refresh entry never competes with an ordinary refresh already on the pins.

// File: rtl/drfs_pkg.sv
package drfs_pkg;

   typedef enum logic [2:0] {
      SQ_PAUSE,
      SQ_INIT,
      SQ_RUN,
      SQ_SELF,
      SQ_BURST
   } sq_state_t;

   typedef enum logic [1:0] {
      EN_IDLE,
      EN_SETUP,
      EN_LOW,
      EN_PRE
   } en_state_t;

endpackage

// File: rtl/drfs_tally.sv
module drfs_tally #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last,
   output logic full
);
   localparam int W = $clog2(LIMIT + 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc && cnt != W'(LIMIT)) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign last = inc && (cnt == W'(LIMIT - 1));
   assign full = (cnt == W'(LIMIT));

endmodule

// File: rtl/drfs_pacer.sv
module drfs_pacer #(
   parameter int NORM_IV  = 1562,
   parameter int SLOW_IV  = 3125,
   parameter int MAX_PEND = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic slow,
   input  logic take,
   output logic pending
);
   localparam int MAXIV = (NORM_IV > SLOW_IV) ? NORM_IV : SLOW_IV;
   localparam int CW    = $clog2(MAXIV + 1);
   localparam int PW    = $clog2(MAX_PEND + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic [PW-1:0] pend;
   logic          tick;
   logic          up;
   logic          dn;

   assign lim  = slow ? CW'(SLOW_IV - 1) : CW'(NORM_IV - 1);
   assign tick = en && (cnt >= lim);
   assign up   = tick && (pend != PW'(MAX_PEND));
   assign dn   = take && (pend != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
      end else if (!en) begin
         pend <= '0;
      end else begin
         case ({up, dn})
            2'b10:   pend <= pend + 1'b1;
            2'b01:   pend <= pend - 1'b1;
            default: pend <= pend;
         endcase
      end
   end

   assign pending = (pend != '0);

   // R5: a refresh is only taken when one is waiting
   assert_take_backed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pend != '0);

   // R5: stored demands drain one per issued refresh
   assert_drain_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && pend < $past(pend)) |-> pend == $past(pend) - 1'b1);

endmodule

// File: rtl/drfs_strobe.sv
module drfs_strobe
   import drfs_pkg::*;
#(
   parameter int CSR_CYC     = 1,
   parameter int RAS_LOW_CYC = 5,
   parameter int RP_CYC      = 4,
   parameter int RPS_CYC     = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_long,
   input  logic hold,
   output logic ras_n,
   output logic cas_n,
   output logic busy,
   output logic done
);
   localparam int M1   = (CSR_CYC > RAS_LOW_CYC) ? CSR_CYC : RAS_LOW_CYC;
   localparam int M2   = (RP_CYC > RPS_CYC) ? RP_CYC : RPS_CYC;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXC + 1);

   en_state_t     st;
   logic [CW-1:0] cnt;
   logic          long_q;
   logic [CW-1:0] pre_last;

   assign pre_last = long_q ? CW'(RPS_CYC - 1) : CW'(RP_CYC - 1);
   assign done     = (st == EN_PRE) && (cnt == pre_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= EN_IDLE;
         cnt    <= '0;
         long_q <= 1'b0;
      end else begin
         case (st)
            EN_IDLE: begin
               if (start) begin
                  st     <= EN_SETUP;
                  cnt    <= '0;
                  long_q <= start_long;
               end
            end
            EN_SETUP: begin
               if (cnt == CW'(CSR_CYC - 1)) begin
                  st  <= EN_LOW;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            EN_LOW: begin
               if (cnt >= CW'(RAS_LOW_CYC - 1)) begin
                  if (!hold) begin
                     st  <= EN_PRE;
                     cnt <= '0;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (done) begin
                  st  <= EN_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign ras_n = (st != EN_LOW);
   assign cas_n = !((st == EN_SETUP) || (st == EN_LOW));
   assign busy  = (st != EN_IDLE);

   // R3: RAS only falls after CAS was already low
   assert_cas_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $past(cas_n) == 1'b0);

   // R3: CAS stays low for the whole RAS-low time
   assert_cas_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> !cas_n);

endmodule

// File: rtl/drfs_seq.sv
module drfs_seq
   import drfs_pkg::*;
#(
   parameter int CLK_NS        = 10,
   parameter int PAUSE_CYC     = 20000,
   parameter int INIT_CYCLES   = 8,
   parameter int ROWS          = 4096,
   parameter int RETENTION_CYC = 6400000,
   parameter bit LONG_RET      = 1'b0,
   parameter int BATT_INTERVAL = 3125,
   parameter int CSR_CYC       = 1,
   parameter int CHR_CYC       = 1,
   parameter int RAS_LOW_CYC   = 5,
   parameter int RP_CYC        = 4,
   parameter int SELF_MIN      = 10000,
   parameter int RPS_CYC       = 9,
   parameter int MAX_PEND      = 8,
   parameter int NCAS          = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_gnt,
   input  logic            lp_req,
   input  logic            slow_pace,
   output logic            ref_req,
   output logic            ready,
   output logic            strobe_en,
   output logic            ras_n,
   output logic [NCAS-1:0] cas_n,
   output logic            we_n
);
   localparam int RET_EFF = LONG_RET ? (2 * RETENTION_CYC) : RETENTION_CYC;
   localparam int NORM_IV = RET_EFF / ROWS;

   if (RAS_LOW_CYC < CHR_CYC) begin : g_bad_chr
      $error("RAS low time shorter than CAS hold after RAS");
   end
   if (RAS_LOW_CYC * CLK_NS >= 300) begin : g_bad_batt
      $error("RAS low time must stay under 300 ns");
   end
   if (CSR_CYC * CLK_NS < 5 || CSR_CYC < 1) begin : g_bad_csr
      $error("CAS setup before RAS too short");
   end
   if (RPS_CYC * CLK_NS < 90) begin : g_bad_rps
      $error("self-refresh exit precharge too short");
   end
   if (INIT_CYCLES < 1 || MAX_PEND < 1 || NORM_IV < 2 || NCAS < 1) begin : g_bad_cfg
      $error("invalid sequencer configuration");
   end

   sq_state_t st;
   logic eng_busy, eng_done, eng_ras_n, eng_cas_n;
   logic eng_start, eng_hold, go_self, go_norm, go_fill, can_go;
   logic pending;
   logic pause_last, pause_full;
   logic init_last, init_full;
   logic burst_last, burst_full;
   logic self_last, self_full;

   assign can_go    = !eng_busy && ref_gnt;
   assign go_self   = (st == SQ_RUN) && can_go && lp_req;
   assign go_norm   = (st == SQ_RUN) && can_go && !lp_req && pending;
   assign go_fill   = ((st == SQ_INIT) || (st == SQ_BURST)) && can_go;
   assign eng_start = go_self || go_norm || go_fill;
   assign eng_hold  = (st == SQ_SELF) && !(self_full && !lp_req);

   drfs_tally #(.LIMIT(PAUSE_CYC)) u_pause (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .inc(st == SQ_PAUSE),
      .last(pause_last), .full(pause_full));

   drfs_tally #(.LIMIT(INIT_CYCLES)) u_init (
      .clk(clk), .rst_n(rst_n), .clr(st != SQ_INIT),
      .inc((st == SQ_INIT) && eng_done),
      .last(init_last), .full(init_full));

   drfs_tally #(.LIMIT(ROWS)) u_burst (
      .clk(clk), .rst_n(rst_n), .clr(st != SQ_BURST),
      .inc((st == SQ_BURST) && eng_done),
      .last(burst_last), .full(burst_full));

   drfs_tally #(.LIMIT(SELF_MIN)) u_selfmin (
      .clk(clk), .rst_n(rst_n), .clr(st != SQ_SELF),
      .inc((st == SQ_SELF) && !eng_ras_n),
      .last(self_last), .full(self_full));

   drfs_pacer #(.NORM_IV(NORM_IV), .SLOW_IV(BATT_INTERVAL), .MAX_PEND(MAX_PEND)) u_pacer (
      .clk(clk), .rst_n(rst_n), .en(st == SQ_RUN), .slow(slow_pace),
      .take(go_norm), .pending(pending));

   drfs_strobe #(.CSR_CYC(CSR_CYC), .RAS_LOW_CYC(RAS_LOW_CYC),
                 .RP_CYC(RP_CYC), .RPS_CYC(RPS_CYC)) u_strobe (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .start_long(go_self),
      .hold(eng_hold), .ras_n(eng_ras_n), .cas_n(eng_cas_n),
      .busy(eng_busy), .done(eng_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SQ_PAUSE;
      end else begin
         case (st)
            SQ_PAUSE: if (pause_last) st <= SQ_INIT;
            SQ_INIT:  if (init_last)  st <= SQ_RUN;
            SQ_RUN:   if (go_self)    st <= SQ_SELF;
            SQ_SELF:  if (eng_done)   st <= SQ_BURST;
            SQ_BURST: if (burst_last) st <= SQ_RUN;
            default:  st <= SQ_PAUSE;
         endcase
      end
   end

   assign ref_req   = (st == SQ_INIT) || (st == SQ_SELF) || (st == SQ_BURST) ||
                      ((st == SQ_RUN) && (pending || lp_req)) || eng_busy;
   assign ready     = (st == SQ_RUN);
   assign strobe_en = eng_busy;
   assign ras_n     = eng_ras_n;
   assign we_n      = 1'b1;

   for (genvar i = 0; i < NCAS; i++) begin : g_cas
      assign cas_n[i] = eng_cas_n;
   end

   // R6: a refresh cycle only begins under a grant
   assert_start_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_busy) |-> $past(ref_gnt));

   // R7: self-refresh is not left before its minimum time
   assert_self_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SQ_SELF) && $rose(ras_n)) |-> self_full);

   // R9: normal access resumes only from init or post-exit burst
   assert_ready_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(st) == SQ_INIT || $past(st) == SQ_BURST));

   // R2: strobes are idle when access is handed back
   assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (ras_n && cas_n == '1));

   // R1: no request during the power-up pause
   assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_PAUSE) |-> (!ref_req && ras_n));

endmodule

// File: tb/drfs_seq_bench.sv
`timescale 1ns/1ps
module drfs_seq_bench;
   localparam int P    = 40;
   localparam int NI   = 8;
   localparam int RW   = 8;
   localparam int RET  = 1600;
   localparam int IV   = RET / RW;
   localparam int BI   = 300;
   localparam int CSR  = 1;
   localparam int RLOW = 5;
   localparam int SMIN = 60;
   localparam int RPS  = 9;
   localparam int MP   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b1, lp_req = 1'b0, slow_pace = 1'b0;
   logic ref_req, ready, strobe_en, ras_n, we_n;
   logic [1:0] cas_n;

   int nchk = 0, nfail = 0, cyc = 0, ras_falls = 0;
   int cas_run = 0, low_run = 0;
   logic prev_ras = 1'b1;
   bit self_phase = 1'b0;
   int t0, fb, n;

   always #2.5 clk = ~clk;

   drfs_seq #(
      .PAUSE_CYC(P), .INIT_CYCLES(NI), .ROWS(RW), .RETENTION_CYC(RET),
      .LONG_RET(1'b0), .BATT_INTERVAL(BI), .CSR_CYC(CSR), .CHR_CYC(1),
      .RAS_LOW_CYC(RLOW), .RP_CYC(4), .SELF_MIN(SMIN), .RPS_CYC(RPS),
      .MAX_PEND(MP), .NCAS(2)
   ) u_drfs_seq (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .lp_req(lp_req),
      .slow_pace(slow_pace), .ref_req(ref_req), .ready(ready),
      .strobe_en(strobe_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   // waveform monitor for every refresh
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (prev_ras && !ras_n) begin
            ras_falls++;
            chk(cas_run >= CSR, "R3 cas setup", cas_run, CSR);
            chk(we_n == 1'b1, "R3 we high", int'(we_n), 1);
         end
         if (!prev_ras && ras_n && !self_phase)
            chk(low_run == RLOW, "R3 ras width", low_run, RLOW);
         if (!ras_n && cas_n != 2'b00)
            chk(1'b0, "R3 cas held", int'(cas_n), 0);
         if (!ras_n) low_run++; else low_run = 0;
         if (cas_n == 2'b00 && ras_n) cas_run++;
         else if (cas_n != 2'b00) cas_run = 0;
         if (!ref_gnt && !prev_ras == ras_n)
            chk(1'b0, "R6 moved without grant", 0, 1);
         prev_ras = ras_n;
      end
   end

   task automatic self_cycle(input int hold_cyc, input int min_low);
      self_phase = 1'b1;
      lp_req = 1'b1;
      while (ras_n) @(negedge clk);
      chk(ready == 1'b0, "R11 ready in self", int'(ready), 0);
      n = 0;
      while (!ras_n) begin
         @(negedge clk);
         n++;
         if (n == hold_cyc) lp_req = 1'b0;
      end
      chk(n >= min_low && n <= min_low + 3, "R7 self low time", n, min_low);
      fb = ras_falls;
      n = 0;
      while (ras_n) begin
         @(negedge clk);
         n++;
      end
      chk(n >= RPS, "R8 exit precharge", n, RPS);
      self_phase = 1'b0;
      while (!ready) @(negedge clk);
      chk(ras_falls - fb == RW, "R9 burst rows", ras_falls - fb, RW);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(ras_n == 1'b1 && cas_n == 2'b11, "R1 reset strobes", int'({ras_n, cas_n}), 7);
      chk(!ready && !ref_req && !strobe_en, "R1 reset flags",
          int'({ready, ref_req, strobe_en}), 0);
      rst_n = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!ref_req && n < 1000);
      chk(n == P, "R1 pause length", n, P);
      chk(ras_falls == 0, "R1 no strobe in pause", ras_falls, 0);
      while (!ready) @(negedge clk);
      chk(ras_falls == NI, "R2 init cycles", ras_falls, NI);
      t0 = cyc;
      fb = ras_falls;
      ref_gnt = 1'b0;
      wait_until(t0 + 3 * IV + 10);
      chk(ras_falls == fb, "R6 no refresh without grant", ras_falls - fb, 0);
      chk(ref_req == 1'b1, "R6 request while waiting", int'(ref_req), 1);
      chk(ready == 1'b1, "R11 ready in run", int'(ready), 1);
      ref_gnt = 1'b1;
      wait_until(t0 + 4 * IV - 20);
      chk(ras_falls - fb == 3, "R5 postponed three", ras_falls - fb, 3);
      ref_gnt = 1'b0;
      fb = ras_falls;
      wait_until(t0 + 16 * IV + 10);
      chk(ras_falls == fb, "R6 no refresh without grant", ras_falls - fb, 0);
      ref_gnt = 1'b1;
      wait_until(t0 + 17 * IV - 20);
      chk(ras_falls - fb == MP, "R5 saturated backlog", ras_falls - fb, MP);
      wait_until(t0 + 17 * IV + 50);
      fb = ras_falls;
      wait_until(t0 + 22 * IV + 50);
      chk(ras_falls - fb == 5, "R4 normal pace", ras_falls - fb, 5);
      wait_until(t0 + 22 * IV + 100);
      slow_pace = 1'b1;
      wait_until(t0 + 22 * IV + 350);
      fb = ras_falls;
      wait_until(t0 + 22 * IV + 1850);
      chk(ras_falls - fb == 5, "R10 battery pace", ras_falls - fb, 5);
      slow_pace = 1'b0;
      wait_until(t0 + 22 * IV + 1905);
      chk(ready == 1'b1, "R11 ready before self", int'(ready), 1);
      self_cycle(10, SMIN + 1);
      chk(ready == 1'b1, "R9 ready after burst", int'(ready), 1);
      self_cycle(SMIN + 90, SMIN + 90);
      chk(ready == 1'b1, "R9 ready after second burst", int'(ready), 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule